// File: doc/BRIEF.md
# Register Dependency Matrix with Latest-Writer Renaming

This block tracks, for every function unit (FU) of an out-of-order core, the registers that unit still has to read and the registers it still has to write. Register selections come in and are stored as fully decoded one-hot vectors, with one wire per register and no encoded index. Alongside the read and write marks, each register column carries a single ownership bit. That bit names the unit that will produce the newest value of the register. When a new writer issues, the bit moves to the new writer, so the ownership bits serve as a renaming table built from one-bit cells.

When an instruction is issued to a free unit, the block looks up the current owner of every source register. It records a read-after-write (RAW) dependency on each owner it finds. Each unit row runs a small state machine with three states:

- `U_FREE`: the row is idle.
- `U_READ`: operands are still outstanding.
- `U_WRITE`: operands have been read and the result is still to be written.

The transitions are:

- ISSUE: `U_FREE` to `U_READ` when the instruction has sources. If it has no sources, ISSUE goes to `U_WRITE` when it has a destination, and otherwise the row stays in `U_FREE`.
- READ_DONE: `U_READ` to `U_WRITE`. If the row has no destination, READ_DONE goes to `U_FREE`.
- WRITE_DONE: `U_WRITE` to `U_FREE`.

Several rows may feed one ALU, so each row acts as a reservation station that waits on its own producers.

Top module: `reg_dep_matrix`

## Requirements
- R1: While reset is asserted and after it is released, `pend_rd`, `pend_wr` and `raw_dep` are all zero.
- R2: An issue accepted by a free unit shows its source bits in `pend_rd` and its destination bits in `pend_wr` on the next cycle. Bit r of every register vector stands for register r.
- R3: On the cycle after issue to unit u, bit `u*NUM_UNITS+p` of `raw_dep` is 1 exactly when some source register of that instruction had unit p as its latest writer.
- R4: At most one unit owns the latest-writer bit of a register. A new writer of register r takes the bit from the previous owner, and later readers of r depend only on the new owner.
- R5: A source register with no latest writer creates no dependency.
- R6: An instruction that reads and writes the same register depends on that register's previous owner and never on its own unit, and it becomes the new owner.
- R7: A read-done strobe for a unit in the read phase clears that unit's read marks and its dependency row on the next cycle. A read-done strobe in any other phase is ignored.
- R8: A write-done strobe is accepted only in the write phase. It clears the unit's write marks, its latest-writer bits and every row's dependency on that unit on the next cycle. A write-done strobe in any other phase has no effect.
- R9: An issue addressed to a unit that is not free is ignored.
- R10: If the latest writer of a register signals write-done in the same cycle that a reader of that register issues, the reader gets no dependency on it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| issue_valid | input | 1 | Issue strobe |
| issue_unit | input | $clog2(NUM_UNITS) | Index of the unit receiving the instruction |
| issue_src | input | NUM_REGS | One-hot-per-register source selection |
| issue_dst | input | NUM_REGS | One-hot-per-register destination selection |
| rd_done | input | NUM_UNITS | Per-unit operand-read-complete strobes |
| wr_done | input | NUM_UNITS | Per-unit result-write-complete strobes |
| raw_dep | output | NUM_UNITS*NUM_UNITS | Bit u*NUM_UNITS+p: unit u waits on producer p |
| pend_rd | output | NUM_REGS | Registers that some unit still has to read |
| pend_wr | output | NUM_REGS | Registers that some unit still has to write |

## Verification
The bench builds the block with 4 units and 8 registers. At that size, every register vector and every dependency row fits in a short hex literal in a vector table. A few issues are enough to fill all units, so the "issue to a busy unit" case is reached quickly. The same size lets the bench move one register's ownership three times, across a multiply-then-add sequence and a read-and-write-same-register instruction. It also makes a write completion coincide with an issue.

// File: rtl/rdm_pkg.sv
package rdm_pkg;

    // Phase of one function-unit row
    typedef enum logic [1:0] {
        U_FREE  = 2'd0,
        U_READ  = 2'd1,
        U_WRITE = 2'd2
    } unit_state_e;

endpackage

// File: rtl/rdm_dep_lookup.sv
// Finds the producers an issuing instruction must wait on, from the
// latest-writer bits of all rows.
module rdm_dep_lookup #(
    parameter int NUM_UNITS = 8,
    parameter int NUM_REGS  = 32
) (
    input  logic [NUM_UNITS*NUM_REGS-1:0] latest_flat,
    input  logic [NUM_REGS-1:0]           src,
    input  logic [NUM_UNITS-1:0]          wr_fin,
    output logic [NUM_UNITS-1:0]          dep
);

    for (genvar p = 0; p < NUM_UNITS; p++) begin : g_prod
        // A producer that finishes this very cycle is no longer waited on
        assign dep[p] = (|(src & latest_flat[p*NUM_REGS +: NUM_REGS])) & ~wr_fin[p];
    end

endmodule

// File: rtl/rdm_row.sv
// One function-unit row: read marks, write marks, latest-writer bits,
// RAW dependency on other units and the phase state machine.
module rdm_row
    import rdm_pkg::*;
#(
    parameter int NUM_UNITS = 8,
    parameter int NUM_REGS  = 32,
    parameter int ROW_ID    = 0
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 take,
    input  logic [NUM_REGS-1:0]  iss_src,
    input  logic [NUM_REGS-1:0]  iss_dst,
    input  logic [NUM_REGS-1:0]  claim,
    input  logic [NUM_UNITS-1:0] iss_dep,
    input  logic                 rd_done,
    input  logic [NUM_UNITS-1:0] wr_fin,
    output logic [NUM_REGS-1:0]  need_rd,
    output logic [NUM_REGS-1:0]  need_wr,
    output logic [NUM_REGS-1:0]  latest,
    output logic [NUM_UNITS-1:0] dep,
    output logic                 is_free,
    output logic                 is_writing
);

    unit_state_e state_q, state_d;
    logic [NUM_REGS-1:0]  need_rd_d, need_wr_d, latest_d;
    logic [NUM_UNITS-1:0] dep_d;
    logic                 own_fin;

    assign own_fin = wr_fin[ROW_ID];

    // Next-state and next-data logic
    always_comb begin
        state_d   = state_q;
        need_rd_d = need_rd;
        need_wr_d = need_wr;
        latest_d  = latest & ~claim;
        dep_d     = dep & ~wr_fin;
        unique case (state_q)
            U_FREE: begin
                if (take) begin
                    need_rd_d = iss_src;
                    need_wr_d = iss_dst;
                    latest_d  = iss_dst;
                    dep_d     = iss_dep;
                    if (|iss_src)      state_d = U_READ;
                    else if (|iss_dst) state_d = U_WRITE;
                    else               state_d = U_FREE;
                end
            end
            U_READ: begin
                if (rd_done) begin
                    need_rd_d = '0;
                    dep_d     = '0;
                    state_d   = (|need_wr) ? U_WRITE : U_FREE;
                end
            end
            U_WRITE: begin
                if (own_fin) begin
                    need_wr_d = '0;
                    latest_d  = '0;
                    state_d   = U_FREE;
                end
            end
            default: state_d = U_FREE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= U_FREE;
        else        state_q <= state_d;
    end

    // Row storage
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            need_rd <= '0;
            need_wr <= '0;
            latest  <= '0;
            dep     <= '0;
        end else begin
            need_rd <= need_rd_d;
            need_wr <= need_wr_d;
            latest  <= latest_d;
            dep     <= dep_d;
        end
    end

    // Phase outputs
    always_comb begin
        is_free    = (state_q == U_FREE);
        is_writing = (state_q == U_WRITE);
    end

    // R6
    self_dep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dep[ROW_ID] == 1'b0);

    // R4
    latest_sub_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (latest & ~need_wr) == '0);

    // R8
    wr_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        own_fin |=> (need_wr == '0 && latest == '0));

    // R7
    rd_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == U_READ && rd_done) |=> (need_rd == '0 && dep == '0));

    // R2
    take_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (take && is_free) |=> (need_rd == $past(iss_src) && need_wr == $past(iss_dst)));

endmodule

// File: rtl/rdm_column_or.sv
// Per-register summaries over all rows; also guards ownership uniqueness.
module rdm_column_or #(
    parameter int NUM_UNITS = 8,
    parameter int NUM_REGS  = 32
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [NUM_UNITS*NUM_REGS-1:0] need_rd_flat,
    input  logic [NUM_UNITS*NUM_REGS-1:0] need_wr_flat,
    input  logic [NUM_UNITS*NUM_REGS-1:0] latest_flat,
    output logic [NUM_REGS-1:0]           pend_rd,
    output logic [NUM_REGS-1:0]           pend_wr
);

    for (genvar r = 0; r < NUM_REGS; r++) begin : g_col
        logic [NUM_UNITS-1:0] rd_col, wr_col, own_col;
        always_comb begin
            for (int u = 0; u < NUM_UNITS; u++) begin
                rd_col[u]  = need_rd_flat[u*NUM_REGS + r];
                wr_col[u]  = need_wr_flat[u*NUM_REGS + r];
                own_col[u] = latest_flat[u*NUM_REGS + r];
            end
        end
        assign pend_rd[r] = |rd_col;
        assign pend_wr[r] = |wr_col;

        // R4
        one_writer_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $onehot0(own_col));
    end

endmodule

// File: rtl/reg_dep_matrix.sv
module reg_dep_matrix #(
    parameter int NUM_UNITS = 8,
    parameter int NUM_REGS  = 32,
    localparam int UW       = (NUM_UNITS > 1) ? $clog2(NUM_UNITS) : 1
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           issue_valid,
    input  logic [UW-1:0]                  issue_unit,
    input  logic [NUM_REGS-1:0]            issue_src,
    input  logic [NUM_REGS-1:0]            issue_dst,
    input  logic [NUM_UNITS-1:0]           rd_done,
    input  logic [NUM_UNITS-1:0]           wr_done,
    output logic [NUM_UNITS*NUM_UNITS-1:0] raw_dep,
    output logic [NUM_REGS-1:0]            pend_rd,
    output logic [NUM_REGS-1:0]            pend_wr
);

    logic [NUM_UNITS*NUM_REGS-1:0] need_rd_flat, need_wr_flat, latest_flat;
    logic [NUM_UNITS-1:0]          free_vec, writing_vec, wr_fin, iss_dep;
    logic [NUM_REGS-1:0]           claim;
    logic                          fire;

    assign fire   = issue_valid && (int'(issue_unit) < NUM_UNITS) && free_vec[issue_unit];
    assign claim  = fire ? issue_dst : '0;
    assign wr_fin = wr_done & writing_vec;

    rdm_dep_lookup #(.NUM_UNITS(NUM_UNITS), .NUM_REGS(NUM_REGS)) u_lookup (
        .latest_flat (latest_flat),
        .src         (issue_src),
        .wr_fin      (wr_fin),
        .dep         (iss_dep)
    );

    for (genvar u = 0; u < NUM_UNITS; u++) begin : g_row
        logic take;
        assign take = fire && (issue_unit == UW'(u));
        rdm_row #(.NUM_UNITS(NUM_UNITS), .NUM_REGS(NUM_REGS), .ROW_ID(u)) u_row (
            .clk        (clk),
            .rst_n      (rst_n),
            .take       (take),
            .iss_src    (issue_src),
            .iss_dst    (issue_dst),
            .claim      (claim),
            .iss_dep    (iss_dep),
            .rd_done    (rd_done[u]),
            .wr_fin     (wr_fin),
            .need_rd    (need_rd_flat[u*NUM_REGS +: NUM_REGS]),
            .need_wr    (need_wr_flat[u*NUM_REGS +: NUM_REGS]),
            .latest     (latest_flat[u*NUM_REGS +: NUM_REGS]),
            .dep        (raw_dep[u*NUM_UNITS +: NUM_UNITS]),
            .is_free    (free_vec[u]),
            .is_writing (writing_vec[u])
        );
    end

    rdm_column_or #(.NUM_UNITS(NUM_UNITS), .NUM_REGS(NUM_REGS)) u_cols (
        .clk          (clk),
        .rst_n        (rst_n),
        .need_rd_flat (need_rd_flat),
        .need_wr_flat (need_wr_flat),
        .latest_flat  (latest_flat),
        .pend_rd      (pend_rd),
        .pend_wr      (pend_wr)
    );

    // R9
    busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_valid && !fire && rd_done == '0 && wr_done == '0)
            |=> ($stable(pend_rd) && $stable(pend_wr) && $stable(raw_dep)));

endmodule

// File: tb/tb_reg_dep_matrix.sv
module tb_reg_dep_matrix;

    localparam int U  = 4;
    localparam int R  = 8;
    localparam int NV = 17;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          issue_valid;
    logic [1:0]    issue_unit;
    logic [R-1:0]  issue_src, issue_dst;
    logic [U-1:0]  rd_done, wr_done;
    logic [U*U-1:0] raw_dep;
    logic [R-1:0]  pend_rd, pend_wr;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    reg_dep_matrix #(.NUM_UNITS(U), .NUM_REGS(R)) dut (
        .clk(clk), .rst_n(rst_n), .issue_valid(issue_valid), .issue_unit(issue_unit),
        .issue_src(issue_src), .issue_dst(issue_dst), .rd_done(rd_done), .wr_done(wr_done),
        .raw_dep(raw_dep), .pend_rd(pend_rd), .pend_wr(pend_wr)
    );

    // {valid, unit, src, dst, rd_done, wr_done, exp_dep, exp_pend_rd, exp_pend_wr}
    localparam logic [58:0] VEC [NV] = '{
        {1'b1, 2'd2, 8'h0C, 8'h02, 4'h0, 4'h0, 16'h0000, 8'h0C, 8'h02},
        {1'b1, 2'd0, 8'h0A, 8'h10, 4'h0, 4'h0, 16'h0004, 8'h0E, 8'h12},
        {1'b1, 2'd1, 8'h60, 8'h02, 4'h0, 4'h0, 16'h0004, 8'h6E, 8'h12},
        {1'b1, 2'd3, 8'h02, 8'h80, 4'h0, 4'h0, 16'h2004, 8'h6E, 8'h92},
        {1'b0, 2'd0, 8'h00, 8'h00, 4'h4, 4'h0, 16'h2004, 8'h6A, 8'h92},
        {1'b0, 2'd0, 8'h00, 8'h00, 4'h0, 4'h4, 16'h2000, 8'h6A, 8'h92},
        {1'b0, 2'd0, 8'h00, 8'h00, 4'h2, 4'h0, 16'h2000, 8'h0A, 8'h92},
        {1'b1, 2'd2, 8'h02, 8'h02, 4'h0, 4'h0, 16'h2200, 8'h0A, 8'h92},
        {1'b0, 2'd0, 8'h00, 8'h00, 4'h0, 4'h2, 16'h0000, 8'h0A, 8'h92},
        {1'b1, 2'd1, 8'h02, 8'h01, 4'h0, 4'h0, 16'h0040, 8'h0A, 8'h93},
        {1'b0, 2'd0, 8'h00, 8'h00, 4'hC, 4'h0, 16'h0040, 8'h0A, 8'h93},
        {1'b0, 2'd0, 8'h00, 8'h00, 4'h0, 4'h8, 16'h0040, 8'h0A, 8'h13},
        {1'b1, 2'd3, 8'h02, 8'h04, 4'h0, 4'h4, 16'h0000, 8'h0A, 8'h15},
        {1'b1, 2'd0, 8'hF0, 8'h20, 4'h0, 4'h0, 16'h0000, 8'h0A, 8'h15},
        {1'b0, 2'd0, 8'h00, 8'h00, 4'h0, 4'h1, 16'h0000, 8'h0A, 8'h15},
        {1'b0, 2'd0, 8'h00, 8'h00, 4'h4, 4'h0, 16'h0000, 8'h0A, 8'h15},
        {1'b1, 2'd2, 8'h02, 8'h00, 4'h0, 4'h0, 16'h0000, 8'h0A, 8'h15}
    };

    function automatic string tag_of(int i);
        case (i)
            0:       return "R2";
            1:       return "R3";
            2, 3, 9: return "R4";
            4, 6:    return "R7";
            5, 8:    return "R8";
            7:       return "R6";
            10:      return "R7";
            11, 14:  return "R8";
            12:      return "R10";
            13:      return "R9";
            15:      return "R7";
            default: return "R5";
        endcase
    endfunction

    task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic idle_inputs();
        issue_valid = 1'b0; issue_unit = '0; issue_src = '0; issue_dst = '0;
        rd_done = '0; wr_done = '0;
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        idle_inputs();
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        #2;
        // R1 during reset
        check("R1", "raw_dep in reset", 32'(raw_dep), 32'h0);
        check("R1", "pend_rd in reset", 32'(pend_rd), 32'h0);
        check("R1", "pend_wr in reset", 32'(pend_wr), 32'h0);
        @(negedge clk); rst_n = 1'b1;
        @(posedge clk); #2;
        check("R1", "pend_wr after reset", 32'(pend_wr), 32'h0);

        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            issue_valid = VEC[i][58];
            issue_unit  = VEC[i][57:56];
            issue_src   = VEC[i][55:48];
            issue_dst   = VEC[i][47:40];
            rd_done     = VEC[i][39:36];
            wr_done     = VEC[i][35:32];
            @(posedge clk); #2;
            check(tag_of(i), $sformatf("step %0d raw_dep", i), 32'(raw_dep), 32'(VEC[i][31:16]));
            check(tag_of(i), $sformatf("step %0d pend_rd", i), 32'(pend_rd), 32'(VEC[i][15:8]));
            check(tag_of(i), $sformatf("step %0d pend_wr", i), 32'(pend_wr), 32'(VEC[i][7:0]));
        end

        // R1: mid-run reset wipes every row
        @(negedge clk); idle_inputs(); rst_n = 1'b0;
        @(posedge clk); #2;
        check("R1", "raw_dep after mid-run reset", 32'(raw_dep), 32'h0);
        check("R1", "pend_rd after mid-run reset", 32'(pend_rd), 32'h0);
        check("R1", "pend_wr after mid-run reset", 32'(pend_wr), 32'h0);
        @(negedge clk); rst_n = 1'b1;
        @(posedge clk); #2;

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule